// File: doc/BRIEF.md
# Complex Three-Level Delta-Sigma Splitter

This block is a first-order low-pass delta-sigma modulator that treats each baseband sample as one complex number. Every accepted sample is added to a pair of I/Q integrators. The previous quantized value is subtracted in the same step. The integrator vector is then quantized jointly. Its magnitude is mapped to one of three amplitudes (zero, half scale, or a programmable high level). Its angle is mapped to one of sixteen sectors. The quantized vector is fed back with its phase kept, so the loop shapes the error in both amplitude and angle.

The three-level result drives two on/off streams for two separate power branches. The half-scale level turns on the moderate stream. The high level turns on the crest stream. Each stream carries the 4-bit sector code while it is on. The two streams are never on together. The high amplitude used in the feedback comes from the `crest_level` input. This lets the ratio between the two branches be trimmed to match their real output powers.

The decision register is a three-state machine:
- LVL_ZERO: both streams are off.
- LVL_MOD: the moderate stream is on.
- LVL_CREST: the crest stream is on.

Reset forces LVL_ZERO. On every accepted sample, the machine moves to the state chosen by the current integrator magnitude; any state can move to any state. When no sample is accepted, the state holds.

Top module: `cxdsm_demux`

## Requirements
- R1: A synchronous reset (`srst` high at a clock edge) clears both integrators to 0, the state to LVL_ZERO, both stream enables and both phase codes to 0, and `out_valid` to 0. `in_ready` is low while `srst` is high and high otherwise.
- R2: A sample is accepted at an edge where `in_valid` and `in_ready` are both high. `out_valid` is high for exactly the cycle after each accepted sample. Without an accepted sample, every stream output keeps its value.
- R3: On an accepted sample, each integrator becomes its old value, plus the sign-extended input on that axis, minus the feedback on that axis. The result saturates to the 20-bit signed range [-524288, 524287].
- R4: The decision uses the squared magnitude m2 = vi*vi + vq*vq of the integrator pair before the update. Below 8192*8192 the level is zero (LVL_ZERO). From 8192*8192 up to 24576*24576 inclusive it is moderate (LVL_MOD). Above that it is crest (LVL_CREST).
- R5: The phase code is {quadrant, sub}. The quadrant is 0 for I>=0,Q>=0; 1 for I<0,Q>=0; 2 for I<0,Q<0; 3 for I>=0,Q<0. Let a=|I| and b=|Q|. Then x=a and y=b in quadrants 0 and 2, and x=b and y=a in quadrants 1 and 3. With T=27146: sub=0 if y*65536 < x*T, else 1 if y < x, else 2 if x*65536 > y*T, else 3. A vector at angle (2c+1)*11.25 degrees gets code c.
- R6: On every accepted sample the feedback on each axis is floor(A*u/32768). A is 0 for zero, 16384 for moderate, and `crest_level` for crest. u is the I or Q part of round(32768*exp(j*(2c+1)*11.25 degrees)) for the chosen code c.
- R7: On each accepted sample, the registered outputs take the decision made from the integrator state before that sample's update. `mod_on` is 1 only for moderate and `crest_on` is 1 only for crest; they are never 1 together. The phase output of a stream equals the code while that stream is on and is 0 while it is off.
- R8: `crest_level` (32768 = full scale) changes only the crest feedback amplitude. A constant input of 30000 on I settles to crest on every sample when `crest_level` is 28180. It does not when `crest_level` is 32768.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| srst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can take a sample (high outside reset) |
| in_i | input | 16 | In-phase sample, signed Q1.15 |
| in_q | input | 16 | Quadrature sample, signed Q1.15 |
| crest_level | input | 16 | High feedback amplitude, unsigned, 32768 = 1.0 |
| out_valid | output | 1 | Pulse one cycle after an accepted sample |
| mod_on | output | 1 | Moderate stream enable |
| mod_phase | output | 4 | Sector code of the moderate stream, 0 when off |
| crest_on | output | 1 | Crest stream enable |
| crest_phase | output | 4 | Sector code of the crest stream, 0 when off |

## Verification
Some properties are checked by assertions on every cycle:
- the two streams are never on together;
- the state holds when no sample is taken;
- `out_valid` follows every accepted sample;
- a saturated integrator does not wrap when pushed further.

Other behaviour can only be shown by the bench's scenarios, which compare against an independent model:
- the threshold boundaries at 8192 and 24576;
- the sixteen sector codes;
- the rounding of the feedback;
- the effect of `crest_level` on crest density;
- recovery from saturation after a full-scale input is removed.

// File: rtl/cxdsm_pkg.sv
package cxdsm_pkg;

    localparam int SAMPLE_W  = 16;
    localparam int ACC_W     = 20;
    localparam int LEVEL_W   = 16;
    localparam int PHASE_W   = 4;
    localparam int UNIT_W    = 16;
    localparam int TAN_FRAC  = 16;
    // tan(22.5 deg) scaled by 2**TAN_FRAC
    localparam logic [TAN_FRAC-1:0] TAN_SECTOR = 16'd27146;

    typedef enum logic [1:0] {
        LVL_ZERO  = 2'd0,
        LVL_MOD   = 2'd1,
        LVL_CREST = 2'd2
    } level_e;

    typedef struct packed {
        logic signed [UNIT_W-1:0] re;
        logic signed [UNIT_W-1:0] im;
    } cplx_t;

    // cos((2s+1)*11.25 deg) in Q1.15
    function automatic logic signed [UNIT_W-1:0] base_cos(input logic [1:0] s);
        logic signed [UNIT_W-1:0] r;
        case (s)
            2'd0:    r = 16'sd32138;
            2'd1:    r = 16'sd27246;
            2'd2:    r = 16'sd18205;
            default: r = 16'sd6393;
        endcase
        return r;
    endfunction

    // unit vector at the centre of sector code
    function automatic cplx_t unit_vec(input logic [PHASE_W-1:0] code);
        cplx_t b;
        cplx_t r;
        b.re = base_cos(code[1:0]);
        b.im = base_cos(2'd3 - code[1:0]);
        case (code[3:2])
            2'd0: r = b;
            2'd1: begin r.re = -b.im; r.im =  b.re; end
            2'd2: begin r.re = -b.re; r.im = -b.im; end
            default: begin r.re = b.im; r.im = -b.re; end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cxdsm_integ.sv
module cxdsm_integ #(
    parameter int DATA_W = 16,
    parameter int FB_W   = 18,
    parameter int ACC_W  = 20
) (
    input  logic                     clk,
    input  logic                     srst,
    input  logic                     en,
    input  logic signed [DATA_W-1:0] x,
    input  logic signed [FB_W-1:0]   fb,
    output logic signed [ACC_W-1:0]  acc
);

    localparam int SUM_W = ACC_W + 2;
    localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

    logic signed [SUM_W-1:0] delta;
    logic signed [SUM_W-1:0] sum;
    logic signed [ACC_W-1:0] acc_d;
    logic signed [ACC_W-1:0] acc_q;

    always_comb begin
        delta = SUM_W'(x) - SUM_W'(fb);
        sum   = SUM_W'(acc_q) + delta;
        if (sum > SUM_W'(ACC_MAX))
            acc_d = ACC_MAX;
        else if (sum < SUM_W'(ACC_MIN))
            acc_d = ACC_MIN;
        else
            acc_d = sum[ACC_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (srst)
            acc_q <= '0;
        else if (en)
            acc_q <= acc_d;
    end

    assign acc = acc_q;

    AST_SAT_HIGH: assert property (@(posedge clk) disable iff (srst)
        (en && acc_q == ACC_MAX && delta > 0) |=> (acc_q == ACC_MAX)); // R3
    AST_SAT_LOW: assert property (@(posedge clk) disable iff (srst)
        (en && acc_q == ACC_MIN && delta < 0) |=> (acc_q == ACC_MIN)); // R3

endmodule

// File: rtl/cxdsm_quant.sv
module cxdsm_quant
    import cxdsm_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ACC_W  = 20
) (
    input  logic signed [ACC_W-1:0] vi,
    input  logic signed [ACC_W-1:0] vq,
    output level_e                  level,
    output logic [PHASE_W-1:0]      code
);

    localparam int MAG_W = ACC_W + 1;
    localparam int SQ_W  = 2 * MAG_W + 1;
    localparam int TP_W  = MAG_W + TAN_FRAC;
    localparam longint LO_MAG = longint'(1) << (DATA_W - 3);
    localparam longint HI_MAG = 3 * LO_MAG;
    localparam logic [SQ_W-1:0] LO_SQ = SQ_W'(LO_MAG * LO_MAG);
    localparam logic [SQ_W-1:0] HI_SQ = SQ_W'(HI_MAG * HI_MAG);

    logic signed [MAG_W-1:0] ei, eq;
    logic [MAG_W-1:0] ai, aq, ax, ay;
    logic [SQ_W-1:0]  mag2;
    logic [TP_W-1:0]  y_sh, x_sh, x_t, y_t;
    logic [1:0]       quad;
    logic [1:0]       sub;

    always_comb begin
        ei   = {vi[ACC_W-1], vi};
        eq   = {vq[ACC_W-1], vq};
        ai   = ei[MAG_W-1] ? MAG_W'(-ei) : MAG_W'(ei);
        aq   = eq[MAG_W-1] ? MAG_W'(-eq) : MAG_W'(eq);
        mag2 = SQ_W'(ai) * SQ_W'(ai) + SQ_W'(aq) * SQ_W'(aq);

        if (mag2 < LO_SQ)
            level = LVL_ZERO;
        else if (mag2 <= HI_SQ)
            level = LVL_MOD;
        else
            level = LVL_CREST;

        quad = {vq[ACC_W-1], vi[ACC_W-1] ^ vq[ACC_W-1]};
        ax   = quad[0] ? aq : ai;
        ay   = quad[0] ? ai : aq;
        y_sh = TP_W'(ay) << TAN_FRAC;
        x_sh = TP_W'(ax) << TAN_FRAC;
        x_t  = TP_W'(ax) * TP_W'(TAN_SECTOR);
        y_t  = TP_W'(ay) * TP_W'(TAN_SECTOR);

        if (y_sh < x_t)
            sub = 2'd0;
        else if (ay < ax)
            sub = 2'd1;
        else if (x_sh > y_t)
            sub = 2'd2;
        else
            sub = 2'd3;

        code = {quad, sub};
    end

endmodule

// File: rtl/cxdsm_fbgen.sv
module cxdsm_fbgen
    import cxdsm_pkg::*;
#(
    parameter int LVL_W   = 16,
    parameter int FB_W    = 18,
    parameter int MOD_AMP = 16384
) (
    input  level_e                  level,
    input  logic [PHASE_W-1:0]      code,
    input  logic [LVL_W-1:0]        crest_level,
    output logic signed [FB_W-1:0]  fb_i,
    output logic signed [FB_W-1:0]  fb_q
);

    localparam int PROD_W = LVL_W + 1 + UNIT_W;
    localparam logic [LVL_W-1:0] MOD_VAL = LVL_W'(MOD_AMP);

    cplx_t                    u;
    logic [LVL_W-1:0]         amp;
    logic signed [PROD_W-1:0] prod_i, prod_q, sh_i, sh_q;

    always_comb begin
        u = unit_vec(code);
        unique case (level)
            LVL_ZERO:  amp = '0;
            LVL_MOD:   amp = MOD_VAL;
            LVL_CREST: amp = crest_level;
            default:   amp = '0;
        endcase
        prod_i = PROD_W'($signed({1'b0, amp})) * PROD_W'(u.re);
        prod_q = PROD_W'($signed({1'b0, amp})) * PROD_W'(u.im);
        sh_i   = prod_i >>> (UNIT_W - 1);
        sh_q   = prod_q >>> (UNIT_W - 1);
        fb_i   = sh_i[FB_W-1:0];
        fb_q   = sh_q[FB_W-1:0];
    end

endmodule

// File: rtl/cxdsm_demux.sv
module cxdsm_demux
    import cxdsm_pkg::*;
#(
    parameter int DATA_W = SAMPLE_W,
    parameter int INT_W  = ACC_W,
    parameter int LVL_W  = LEVEL_W
) (
    input  logic                      clk,
    input  logic                      srst,
    input  logic                      in_valid,
    output logic                      in_ready,
    input  logic signed [DATA_W-1:0]  in_i,
    input  logic signed [DATA_W-1:0]  in_q,
    input  logic [LVL_W-1:0]          crest_level,
    output logic                      out_valid,
    output logic                      mod_on,
    output logic [PHASE_W-1:0]        mod_phase,
    output logic                      crest_on,
    output logic [PHASE_W-1:0]        crest_phase
);

    localparam int FB_W    = LVL_W + 2;
    localparam int MOD_AMP = 2 ** (DATA_W - 2);
    localparam int AXES    = 2;

    logic                     accept;
    logic signed [DATA_W-1:0] x_ax   [AXES];
    logic signed [FB_W-1:0]   fb_ax  [AXES];
    logic signed [INT_W-1:0]  acc_ax [AXES];
    level_e                   lvl_d, lvl_q;
    logic [PHASE_W-1:0]       code_d, code_q;

    assign in_ready = ~srst;
    assign accept   = in_valid & in_ready;
    assign x_ax[0]  = in_i;
    assign x_ax[1]  = in_q;

    for (genvar ax = 0; ax < AXES; ax++) begin : g_axis
        cxdsm_integ #(
            .DATA_W (DATA_W),
            .FB_W   (FB_W),
            .ACC_W  (INT_W)
        ) u_integ (
            .clk  (clk),
            .srst (srst),
            .en   (accept),
            .x    (x_ax[ax]),
            .fb   (fb_ax[ax]),
            .acc  (acc_ax[ax])
        );
    end

    cxdsm_quant #(
        .DATA_W (DATA_W),
        .ACC_W  (INT_W)
    ) u_quant (
        .vi    (acc_ax[0]),
        .vq    (acc_ax[1]),
        .level (lvl_d),
        .code  (code_d)
    );

    cxdsm_fbgen #(
        .LVL_W   (LVL_W),
        .FB_W    (FB_W),
        .MOD_AMP (MOD_AMP)
    ) u_fbgen (
        .level       (lvl_d),
        .code        (code_d),
        .crest_level (crest_level),
        .fb_i        (fb_ax[0]),
        .fb_q        (fb_ax[1])
    );

    // state register
    always_ff @(posedge clk) begin
        if (srst) begin
            lvl_q     <= LVL_ZERO;
            code_q    <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= accept;
            if (accept) begin
                lvl_q  <= lvl_d;
                code_q <= code_d;
            end
        end
    end

    // outputs from state
    always_comb begin
        mod_on      = 1'b0;
        crest_on    = 1'b0;
        mod_phase   = '0;
        crest_phase = '0;
        unique case (lvl_q)
            LVL_ZERO: ;
            LVL_MOD: begin
                mod_on    = 1'b1;
                mod_phase = code_q;
            end
            LVL_CREST: begin
                crest_on    = 1'b1;
                crest_phase = code_q;
            end
            default: ;
        endcase
    end

    AST_STREAMS_EXCLUSIVE: assert property (@(posedge clk) disable iff (srst)
        !(mod_on && crest_on)); // R7
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (srst)
        !accept |=> ($stable(lvl_q) && $stable(code_q))); // R2
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (srst)
        accept |=> out_valid); // R2
    AST_NO_VALID_IDLE: assert property (@(posedge clk) disable iff (srst)
        !accept |=> !out_valid); // R2

endmodule

// File: tb/cxdsm_demux_test.sv
`timescale 1ns/1ps
module cxdsm_demux_test;

    logic               clk = 1'b0;
    logic               srst = 1'b1;
    logic               in_valid = 1'b0;
    logic               in_ready;
    logic signed [15:0] in_i = '0;
    logic signed [15:0] in_q = '0;
    logic [15:0]        crest_level = 16'd30000;
    logic               out_valid;
    logic               mod_on, crest_on;
    logic [3:0]         mod_phase, crest_phase;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 1'b0;
    longint mvi = 0, mvq = 0;
    logic [9:0] exp_out = '0;

    localparam longint LO2 = 64'd8192 * 64'd8192;
    localparam longint HI2 = 64'd24576 * 64'd24576;

    always #4 clk = ~clk;

    cxdsm_demux uut (
        .clk(clk), .srst(srst), .in_valid(in_valid), .in_ready(in_ready),
        .in_i(in_i), .in_q(in_q), .crest_level(crest_level),
        .out_valid(out_valid), .mod_on(mod_on), .mod_phase(mod_phase),
        .crest_on(crest_on), .crest_phase(crest_phase)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic longint sat20(input longint v);
        if (v > 524287) return 524287;
        if (v < -524288) return -524288;
        return v;
    endfunction

    function automatic longint uvec(input int code, input bit im);
        real a, r;
        a = (2.0 * code + 1.0) * 11.25 * 3.14159265358979 / 180.0;
        r = 32768.0 * (im ? $sin(a) : $cos(a));
        return longint'(r);
    endfunction

    task automatic model_accept(input longint xi, input longint xq, output logic [9:0] o);
        longint m2, ai, aq, x, y, amp, fi, fq;
        int lvl, code, quad, sub;
        ai = (mvi < 0) ? -mvi : mvi;
        aq = (mvq < 0) ? -mvq : mvq;
        m2 = mvi * mvi + mvq * mvq;
        lvl = (m2 < LO2) ? 0 : ((m2 <= HI2) ? 1 : 2);
        if (mvq < 0) quad = (mvi < 0) ? 2 : 3;
        else         quad = (mvi < 0) ? 1 : 0;
        x = (quad % 2 == 1) ? aq : ai;
        y = (quad % 2 == 1) ? ai : aq;
        if (y * 65536 < x * 27146)      sub = 0;
        else if (y < x)                 sub = 1;
        else if (x * 65536 > y * 27146) sub = 2;
        else                            sub = 3;
        code = quad * 4 + sub;
        o = {lvl == 1, 4'((lvl == 1) ? code : 0), lvl == 2, 4'((lvl == 2) ? code : 0)};
        amp = (lvl == 0) ? 0 : ((lvl == 1) ? 16384 : longint'(crest_level));
        fi = (amp * uvec(code, 1'b0)) >>> 15;
        fq = (amp * uvec(code, 1'b1)) >>> 15;
        mvi = sat20(mvi + xi - fi);
        mvq = sat20(mvq + xq - fq);
    endtask

    // called at a negedge; returns at the next negedge after checking
    task automatic step(input bit v, input int si, input int sq, input string tag);
        logic [9:0] want;
        logic [9:0] got;
        in_valid = v;
        in_i = 16'(si);
        in_q = 16'(sq);
        if (v) begin
            model_accept(longint'(si), longint'(sq), want);
            exp_out = want;
        end
        @(negedge clk);
        got = {mod_on, mod_phase, crest_on, crest_phase};
        chk(out_valid == v, "R2 out_valid", longint'(out_valid), longint'(v));
        chk(got == exp_out, v ? tag : "R2 hold", longint'(got), longint'(exp_out));
        chk(!(mod_on && crest_on), "R7 exclusive", longint'({mod_on, crest_on}), 0);
    endtask

    task automatic do_reset();
        in_valid = 1'b0;
        srst = 1'b1;
        repeat (3) @(negedge clk);
        chk(in_ready == 1'b0, "R1 in_ready in reset", longint'(in_ready), 0);
        chk({out_valid, mod_on, crest_on, mod_phase, crest_phase} == '0, "R1 outputs clear",
            longint'({out_valid, mod_on, crest_on, mod_phase, crest_phase}), 0);
        srst = 1'b0;
        mvi = 0; mvq = 0; exp_out = '0;
        #1;
        chk(in_ready == 1'b1, "R1 in_ready after reset", longint'(in_ready), 1);
        @(negedge clk);
    endtask

    // feed one vector after reset, then look at the decision of that vector
    task automatic probe(input int si, input int sq, input logic [9:0] want, input string tag);
        do_reset();
        step(1'b1, si, sq, tag);
        step(1'b1, 0, 0, tag);
        chk({mod_on, mod_phase, crest_on, crest_phase} == want, tag,
            longint'({mod_on, mod_phase, crest_on, crest_phase}), longint'(want));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R2 watchdog: actual hung expected done");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int crest_cnt;
        void'($urandom(32'd4242));
        @(negedge clk);
        do_reset();

        // R4: all-zero input stays off
        for (int k = 0; k < 20; k++) step(1'b1, 0, 0, "R4 zero input");

        // R4 threshold boundaries (code 0 on the positive I axis)
        probe(8191,  0, 10'b0_0000_0_0000, "R4 below low threshold");
        probe(8192,  0, 10'b1_0000_0_0000, "R4 at low threshold");
        probe(24576, 0, 10'b1_0000_0_0000, "R4 at high threshold");
        probe(24577, 0, 10'b0_0000_1_0000, "R4 above high threshold");

        // R5: one vector at the centre of every sector
        for (int c = 0; c < 16; c++) begin
            real a;
            a = (2.0 * c + 1.0) * 11.25 * 3.14159265358979 / 180.0;
            probe(int'(16000.0 * $cos(a)), int'(16000.0 * $sin(a)),
                  {1'b1, 4'(c), 1'b0, 4'd0}, "R5 sector code");
        end

        // R6/R7: moderate DC input
        do_reset();
        for (int k = 0; k < 60; k++) step(1'b1, 12000, -5000, "R6 dc moderate");

        // R2/R6: sinusoid with random gaps
        crest_level = 16'd30000;
        do_reset();
        for (int k = 0; k < 2000; k++) begin
            real ph;
            bit v;
            ph = 2.0 * 3.14159265358979 * k / 97.0;
            v = ($urandom_range(0, 9) < 8);
            step(v, int'(20000.0 * $cos(ph)), int'(20000.0 * $sin(ph)), "R6 sinusoid");
        end

        // R8: crest_level changes the crest density
        crest_level = 16'd28180;
        do_reset();
        crest_cnt = 0;
        for (int k = 0; k < 300; k++) begin
            step(1'b1, 30000, 0, "R8 low crest level");
            if (k >= 200 && crest_on) crest_cnt++;
        end
        chk(crest_cnt == 100, "R8 crest every sample at 28180", crest_cnt, 100);
        crest_level = 16'd32768;
        do_reset();
        crest_cnt = 0;
        for (int k = 0; k < 300; k++) begin
            step(1'b1, 30000, 0, "R8 full crest level");
            if (k >= 200 && crest_on) crest_cnt++;
        end
        chk(crest_cnt < 100, "R8 crest not every sample at 32768", crest_cnt, 99);

        // R3: drive into saturation, then release
        crest_level = 16'd28180;
        do_reset();
        for (int k = 0; k < 200; k++) step(1'b1, 32767, -32768, "R3 saturating drive");
        for (int k = 0; k < 300; k++) step(1'b1, 0, 0, "R3 saturation recovery");

        // random full-range input with random gaps
        crest_level = 16'(28180 + $urandom_range(0, 4588));
        do_reset();
        for (int k = 0; k < 2000; k++) begin
            bit v;
            v = ($urandom_range(0, 3) != 0);
            step(v, $urandom_range(0, 65535) - 32768, $urandom_range(0, 65535) - 32768,
                 "R6 random input");
        end

        // R1: reset in the middle of activity clears everything
        do_reset();
        for (int k = 0; k < 10; k++) step(1'b1, 0, 0, "R1 cleared after reset");

        finished = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule